// File: doc/BRIEF.md
# Reset Cause Recorder with Pre-Reset Interrupt

This block collects reset requests from a set of on-chip sources and turns them into one system reset output. It keeps two views of why the chip was reset. The first is a "latest cause" word that holds only the sources behind the most recent reset. The second is an accumulating "history" word. The history word gathers every cause seen since the last power-on or low-voltage event, and it keeps each bit until software clears it.

Software can ask for warning before a reset takes effect. There is a global enable and a per-source enable mask. When a requesting source is enabled, the block raises an interrupt first. It then holds the system reset back for a programmable number of clock cycles, which gives firmware time to save state.

Power-on and low-voltage detection are analog functions and are not part of this block. They arrive here as single-cycle pulses. Each such pulse re-initialises the block and records its own cause.

A small register port gives access to the block. Reads are registered and return data one cycle after the address is presented.

Top module: `rst_cause_rec`

## Requirements
- R1: Cause bit positions in every status word are fixed. Request input `req_i[i]` for i in 0..15 maps to bit i. `req_i[16]` maps to bit 29. The low-voltage pulse maps to bit 30 and the power-on pulse maps to bit 31. Bits 16..28 always read 0. The mask register at address 3 keeps only bits 0..15 and 29, so writing all ones reads back 0x2000FFFF.
- R2: When no pre-reset interrupt applies, `sys_rst_o` goes high on the clock edge that samples the request. It then stays high for exactly RST_CYC cycles (default 4).
- R3: The latest-cause word (address 0) is loaded with every pending cause bit at the edge where `sys_rst_o` rises, and requests that coincide set all their bits together. Requests that arrive while `sys_rst_o` is high are recorded in neither the latest-cause word nor the history word.
- R4: The history word (address 2's neighbour, address 1) ORs in each captured cause and keeps it across further resets. Software can clear it in two ways:
  - writing to address 1 clears every bit written as 1;
  - any write to address 4 clears the whole word.
  
  If a capture and a clear hit the same edge, the captured bit is kept.
- R5: A pre-reset interrupt is taken only when both of these hold: the global enable (control bit 0 at address 2) is 1, and the mask bit of at least one requesting source is 1. When it is taken, `irq_o` goes high on the sampling edge, and `sys_rst_o` rises D edges later on the same edge where `irq_o` falls. Otherwise the R2 path is used.
- R6: The delay D is selected by control bits [3:1]. Codes 0 to 6 give 8 << code cycles (8 up to 512), and code 7 saturates to 512.
- R7: Requests that arrive while the interrupt is pending are merged into the pending set. They appear in the latest-cause word when the reset asserts.
- R8: The effect of a control write depends on bit 0 of the written word:
  - with bit 0 = 1, the delay code is loaded from bits [3:1];
  - with bit 0 = 0 and bit 8 = 1, the delay code returns to 0;
  - with bit 0 = 0 and bit 8 = 0, the delay code is kept.
  
  Control reads back as {delay code, enable} in bits [3:0].
- R9: A power-on (`por_i`) or low-voltage (`lvd_i`) pulse has the following effects one edge later:
  - the history and latest-cause words hold only that pulse's own bit;
  - control and mask return to 0;
  - any pending interrupt or reset sequence is cancelled.
- R10: `irq_o` and `sys_rst_o` are never high in the same cycle.
- R11: `reg_rdata` shows the register selected by `reg_addr` one cycle later. Address 4 and unused addresses read 0. After `rst`, every register reads 0 and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_i | input | 1 | Power-on event pulse |
| lvd_i | input | 1 | Low-voltage event pulse |
| req_i | input | 17 | Reset requests, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Pre-reset interrupt |
| sys_rst_o | output | 1 | System reset request |

## Verification
The assertions check four things on every cycle:
- the interrupt and the reset are never high together;
- a rise of the reset always follows either a request or a pending interrupt;
- the interrupt ends only when the reset starts or when a power event occurs;
- the latest-cause word is a subset of the history word when the reset rises, and it holds still while the reset stays high.

Some behaviours can only be shown by the bench's scenarios: the exact delay counts for each code, the merge of late requests, the set-over-clear priority, and the control-write rules for the delay field. The bench also shows which requests are ignored during an active reset, and how power events re-initialise the block.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int WORD_W  = 32;
  localparam int LO_SRCS = 16;
  localparam int POS_EXT = 29;
  localparam int POS_LVD = 30;
  localparam int POS_POR = 31;

  localparam logic [WORD_W-1:0] REQ_MASK =
    ((WORD_W'(1) << LO_SRCS) - WORD_W'(1)) | (WORD_W'(1) << POS_EXT);

  localparam logic [2:0] ADR_LAST   = 3'd0;
  localparam logic [2:0] ADR_HIST   = 3'd1;
  localparam logic [2:0] ADR_CTRL   = 3'd2;
  localparam logic [2:0] ADR_MASK   = 3'd3;
  localparam logic [2:0] ADR_CLRALL = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HOLD,
    ST_RST
  } rcr_state_e;
endpackage

// File: rtl/rcr_src_map.sv
module rcr_src_map
  import rcr_pkg::*;
#(
  parameter int NREQ = LO_SRCS + 1
) (
  input  logic [NREQ-1:0]   req_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] w;

  always_comb begin
    w = '0;
    for (int i = 0; i < LO_SRCS; i++) begin
      w[i] = req_i[i];
    end
    w[POS_EXT] = req_i[LO_SRCS];
  end

  assign word_o = w;
endmodule

// File: rtl/rcr_seq.sv
module rcr_seq
  import rcr_pkg::*;
#(
  parameter int RST_CYC  = 4,
  parameter int BASE_DLY = 8,
  parameter int MAX_DLY  = 512,
  parameter int CODE_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_evt,
  input  logic [WORD_W-1:0] req_word,
  input  logic              gen_en,
  input  logic [WORD_W-1:0] mask,
  input  logic [CODE_W-1:0] dly_code,
  output logic              irq_o,
  output logic              sys_rst_o,
  output logic              cap_valid,
  output logic [WORD_W-1:0] cap_word
);
  localparam int CNT_W    = $clog2(MAX_DLY);
  localparam int MAX_CODE = $clog2(MAX_DLY / BASE_DLY);

  rcr_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] pend_q;
  logic              irq_q, sys_q;
  logic              any_req, want_irq, cnt_zero;
  logic [CNT_W-1:0]  dly_m1;

  always_comb begin
    if (int'(dly_code) > MAX_CODE) dly_m1 = CNT_W'(MAX_DLY - 1);
    else                           dly_m1 = CNT_W'((BASE_DLY << dly_code) - 1);
  end

  assign any_req   = |req_word;
  assign want_irq  = gen_en && (|(req_word & mask));
  assign cnt_zero  = (cnt_q == '0);
  assign cap_valid = !pwr_evt &&
                     ((st_q == ST_IDLE && any_req && !want_irq) ||
                      (st_q == ST_HOLD && cnt_zero));
  assign cap_word  = (st_q == ST_IDLE) ? req_word : (pend_q | req_word);

  always_ff @(posedge clk) begin
    if (rst || pwr_evt) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
      sys_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (any_req) begin
            if (want_irq) begin
              st_q   <= ST_HOLD;
              pend_q <= req_word;
              cnt_q  <= dly_m1;
              irq_q  <= 1'b1;
            end else begin
              st_q  <= ST_RST;
              sys_q <= 1'b1;
              cnt_q <= CNT_W'(RST_CYC - 1);
            end
          end
        end
        ST_HOLD: begin
          if (cnt_zero) begin
            st_q   <= ST_RST;
            irq_q  <= 1'b0;
            sys_q  <= 1'b1;
            pend_q <= '0;
            cnt_q  <= CNT_W'(RST_CYC - 1);
          end else begin
            pend_q <= pend_q | req_word;
            cnt_q  <= cnt_q - CNT_W'(1);
          end
        end
        ST_RST: begin
          if (cnt_zero) begin
            st_q  <= ST_IDLE;
            sys_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign irq_o     = irq_q;
  assign sys_rst_o = sys_q;
endmodule

// File: rtl/rcr_regs.sv
module rcr_regs
  import rcr_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_i,
  input  logic              lvd_i,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              cap_valid,
  input  logic [WORD_W-1:0] cap_word,
  output logic              gen_en,
  output logic [WORD_W-1:0] mask,
  output logic [CODE_W-1:0] dly_code,
  output logic [WORD_W-1:0] last_w,
  output logic [WORD_W-1:0] sticky_w,
  output logic [WORD_W-1:0] reg_rdata
);
  logic [WORD_W-1:0] last_q, hist_q, mask_q, hist_nx, evt_word, rd_nx, rdata_q;
  logic [CODE_W-1:0] code_q;
  logic              en_q;
  logic              wr_hist, wr_ctrl, wr_mask, wr_clr;

  assign wr_hist = reg_wr && (reg_addr == ADDR_W'(ADR_HIST));
  assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(ADR_CTRL));
  assign wr_mask = reg_wr && (reg_addr == ADDR_W'(ADR_MASK));
  assign wr_clr  = reg_wr && (reg_addr == ADDR_W'(ADR_CLRALL));

  always_comb begin
    evt_word = '0;
    evt_word[POS_POR] = por_i;
    evt_word[POS_LVD] = lvd_i;
  end

  always_comb begin
    hist_nx = hist_q;
    if (wr_hist) hist_nx = hist_nx & ~reg_wdata;
    if (wr_clr)  hist_nx = '0;
    if (cap_valid) hist_nx = hist_nx | cap_word;
  end

  always_comb begin
    case (reg_addr)
      ADDR_W'(ADR_LAST): rd_nx = last_q;
      ADDR_W'(ADR_HIST): rd_nx = hist_q;
      ADDR_W'(ADR_CTRL): rd_nx = WORD_W'({code_q, en_q});
      ADDR_W'(ADR_MASK): rd_nx = mask_q;
      default:           rd_nx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q  <= '0;
      hist_q  <= '0;
      mask_q  <= '0;
      code_q  <= '0;
      en_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_nx;
      if (por_i || lvd_i) begin
        last_q <= evt_word;
        hist_q <= evt_word;
        mask_q <= '0;
        code_q <= '0;
        en_q   <= 1'b0;
      end else begin
        hist_q <= hist_nx;
        if (cap_valid) last_q <= cap_word;
        if (wr_mask) mask_q <= reg_wdata & REQ_MASK;
        if (wr_ctrl) begin
          en_q <= reg_wdata[0];
          if (reg_wdata[0])      code_q <= reg_wdata[CODE_W:1];
          else if (reg_wdata[8]) code_q <= '0;
        end
      end
    end
  end

  assign gen_en    = en_q;
  assign mask      = mask_q;
  assign dly_code  = code_q;
  assign last_w    = last_q;
  assign sticky_w  = hist_q;
  assign reg_rdata = rdata_q;
endmodule

// File: rtl/rst_cause_rec.sv
module rst_cause_rec
  import rcr_pkg::*;
#(
  parameter int RST_CYC  = 4,
  parameter int BASE_DLY = 8,
  parameter int MAX_DLY  = 512,
  parameter int CODE_W   = 3,
  parameter int ADDR_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 por_i,
  input  logic                 lvd_i,
  input  logic [LO_SRCS:0]     req_i,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  output logic                 irq_o,
  output logic                 sys_rst_o
);
  localparam int NREQ = LO_SRCS + 1;

  logic [WORD_W-1:0] req_word, mask, cap_word, last_w, sticky_w;
  logic [CODE_W-1:0] dly_code;
  logic              gen_en, cap_valid;

  rcr_src_map #(.NREQ(NREQ)) map_i (
    .req_i (req_i),
    .word_o(req_word)
  );

  rcr_seq #(
    .RST_CYC(RST_CYC), .BASE_DLY(BASE_DLY), .MAX_DLY(MAX_DLY), .CODE_W(CODE_W)
  ) seq_i (
    .clk      (clk),
    .rst      (rst),
    .pwr_evt  (por_i | lvd_i),
    .req_word (req_word),
    .gen_en   (gen_en),
    .mask     (mask),
    .dly_code (dly_code),
    .irq_o    (irq_o),
    .sys_rst_o(sys_rst_o),
    .cap_valid(cap_valid),
    .cap_word (cap_word)
  );

  rcr_regs #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) regs_i (
    .clk      (clk),
    .rst      (rst),
    .por_i    (por_i),
    .lvd_i    (lvd_i),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .cap_valid(cap_valid),
    .cap_word (cap_word),
    .gen_en   (gen_en),
    .mask     (mask),
    .dly_code (dly_code),
    .last_w   (last_w),
    .sticky_w (sticky_w),
    .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/rcr_checker.sv
module rcr_checker
  import rcr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              por_i,
  input logic              lvd_i,
  input logic [LO_SRCS:0]  req_i,
  input logic              irq_o,
  input logic              sys_rst_o,
  input logic [WORD_W-1:0] last_w,
  input logic [WORD_W-1:0] sticky_w
);
  // R10
  irq_rst_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(irq_o && sys_rst_o));

  // R2
  rst_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_o) |-> ($past(irq_o) || $past(|req_i)));

  // R5
  irq_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_o) |-> (sys_rst_o || $past(por_i) || $past(lvd_i)));

  // R4
  last_in_hist_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_o) |-> ((last_w & ~sticky_w) == '0));

  // R3
  last_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sys_rst_o && $past(sys_rst_o)) |-> $stable(last_w));
endmodule

bind rst_cause_rec rcr_checker chk_i (
  .clk      (clk),
  .rst      (rst),
  .por_i    (por_i),
  .lvd_i    (lvd_i),
  .req_i    (req_i),
  .irq_o    (irq_o),
  .sys_rst_o(sys_rst_o),
  .last_w   (last_w),
  .sticky_w (sticky_w)
);

// File: tb/rst_cause_rec_tb_top.sv
module rst_cause_rec_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        por_i = 1'b0, lvd_i = 1'b0;
  logic [16:0] req_i = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o, sys_rst_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_rec dut_i (
    .clk(clk), .rst(rst), .por_i(por_i), .lvd_i(lvd_i), .req_i(req_i),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse_req(input logic [16:0] r);
    @(negedge clk);
    req_i = r;
    @(negedge clk);
    req_i = '0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R11 irq after rst", 32'(irq_o), 0);
    chk("R11 sys_rst after rst", 32'(sys_rst_o), 0);
    rd(3'd0, v); chk("R11 last after rst", v, 0);
    rd(3'd1, v); chk("R11 hist after rst", v, 0);
    rd(3'd2, v); chk("R11 ctrl after rst", v, 0);
    rd(3'd7, v); chk("R11 unused addr", v, 0);
  endtask

  task automatic t_direct();
    logic [31:0] v;
    @(negedge clk);
    req_i = 17'h1_0001;
    @(negedge clk);
    req_i = '0;
    chk("R2 sys_rst on sampling edge", 32'(sys_rst_o), 1);
    for (int i = 1; i < 4; i++) begin
      if (i == 1) req_i = 17'h0_0020;
      @(negedge clk);
      req_i = '0;
      chk("R2 sys_rst held", 32'(sys_rst_o), 1);
    end
    @(negedge clk);
    chk("R2 sys_rst released after 4", 32'(sys_rst_o), 0);
    settle();
    rd(3'd0, v); chk("R3 R1 last coincident causes", v, 32'h2000_0001);
    rd(3'd1, v); chk("R3 hist ignores request in reset", v, 32'h2000_0001);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    pulse_req(17'h0_0080);
    settle();
    rd(3'd0, v); chk("R3 last only newest", v, 32'h0000_0080);
    rd(3'd1, v); chk("R4 hist accumulates", v, 32'h2000_0081);
    wr(3'd1, 32'h0000_0001);
    rd(3'd1, v); chk("R4 w1c single bit", v, 32'h2000_0080);
    @(negedge clk);
    req_i = 17'h0_0008;
    reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h0000_0008;
    @(negedge clk);
    req_i = '0; reg_wr = 1'b0;
    settle();
    rd(3'd1, v); chk("R4 set wins over clear", v, 32'h2000_0088);
    wr(3'd4, 32'h0);
    rd(3'd1, v); chk("R4 clear all", v, 0);
    rd(3'd4, v); chk("R11 clear-all addr reads 0", v, 0);
  endtask

  task automatic t_irq(input logic [2:0] code, input int exp_d, input bit merge);
    logic [31:0] v;
    int n;
    wr(3'd3, 32'h0000_0004);
    wr(3'd2, {28'd0, code, 1'b1});
    @(negedge clk);
    req_i = 17'h0_0004;
    @(negedge clk);
    req_i = '0;
    chk("R5 irq raised", 32'(irq_o), 1);
    chk("R5 no reset yet", 32'(sys_rst_o), 0);
    n = 0;
    while (irq_o && !sys_rst_o && n < 2000) begin
      n++;
      req_i = (merge && n == 2) ? 17'h0_0200 : 17'h0;
      @(negedge clk);
      if (irq_o && sys_rst_o) chk("R10 irq and reset together", 1, 0);
    end
    req_i = '0;
    chk("R6 delay cycles", 32'(n), 32'(exp_d));
    chk("R5 reset after delay", 32'(sys_rst_o), 1);
    chk("R5 irq dropped", 32'(irq_o), 0);
    settle();
    rd(3'd0, v);
    chk("R7 last after pre-irq", v, merge ? 32'h0000_0204 : 32'h0000_0004);
    wr(3'd4, 32'h0);
  endtask

  task automatic t_nomask();
    wr(3'd3, 32'h0000_0004);
    wr(3'd2, 32'h0000_0001);
    @(negedge clk);
    req_i = 17'h0_0010;
    @(negedge clk);
    req_i = '0;
    chk("R5 unmasked source skips irq", 32'(irq_o), 0);
    chk("R5 unmasked source resets", 32'(sys_rst_o), 1);
    settle();
    wr(3'd2, 32'h0000_0000);
    @(negedge clk);
    req_i = 17'h0_0004;
    @(negedge clk);
    req_i = '0;
    chk("R5 global off skips irq", 32'(irq_o), 0);
    chk("R5 global off resets", 32'(sys_rst_o), 1);
    settle();
    wr(3'd4, 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(3'd2, 32'h0000_000B);
    rd(3'd2, v); chk("R8 enable loads code", v, 32'h0000_000B);
    wr(3'd2, 32'h0000_0000);
    rd(3'd2, v); chk("R8 disable keeps code", v, 32'h0000_000A);
    wr(3'd2, 32'h0000_0100);
    rd(3'd2, v); chk("R8 disable clears code", v, 32'h0000_0000);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, v); chk("R1 mask positions", v, 32'h2000_FFFF);
  endtask

  task automatic t_pwr();
    logic [31:0] v;
    wr(3'd3, 32'h0000_0004);
    wr(3'd2, 32'h0000_000F);
    pulse_req(17'h0_0004);
    chk("R9 irq pending before por", 32'(irq_o), 1);
    @(negedge clk);
    por_i = 1'b1;
    @(negedge clk);
    por_i = 1'b0;
    chk("R9 por cancels irq", 32'(irq_o), 0);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (sys_rst_o) begin
        chk("R9 cancelled reset asserted", 1, 0);
        break;
      end
    end
    rd(3'd0, v); chk("R9 last after por", v, 32'h8000_0000);
    rd(3'd1, v); chk("R9 hist after por", v, 32'h8000_0000);
    rd(3'd2, v); chk("R9 ctrl after por", v, 0);
    rd(3'd3, v); chk("R9 mask after por", v, 0);
    @(negedge clk);
    lvd_i = 1'b1;
    @(negedge clk);
    lvd_i = 1'b0;
    rd(3'd1, v); chk("R9 R1 hist after lvd", v, 32'h4000_0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_direct();
    t_sticky();
    t_ctrl();
    t_irq(3'd0, 8, 1'b1);
    t_irq(3'd2, 32, 1'b0);
    t_irq(3'd6, 512, 1'b0);
    t_irq(3'd7, 512, 1'b0);
    t_nomask();
    t_pwr();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule